// File: doc/BRIEF.md
# Serial Debug Bus Board Slave

This block is the board-side endpoint of a bit-serial debug bus. The bus controller drives a shift clock, a serial data line, an address qualifier and an execute line. The qualifier is what tells an address bit apart from a data bit, because both travel on the same serial input. While the qualifier is high, each shift-clock rising edge moves one bit into an 8-bit address register. The upper four bits of that register name a board slot. When they equal the board's own slot number and the qualifier is low, the board is selected.

While the board is selected, shift edges move data through the internal register named by the low four address bits. The bit that falls out of the top of that register appears on the serial output, which is driven only while the board is selected. Register 0 is the configuration register. It sets whether the 5-bit component-select bus is a one-hot decode or a plain binary index. A raised execute line turns a shift edge into an execute cycle, reported as a one-clock strobe with no transfer. Holding the debug reset request together with a synchronous stop for ten clock cycles raises a block reset that clears the address and the registers.

The shift clock, serial lines and qualifiers are sampled on the system clock. They must be synchronous to it and must hold each level for at least one clock. Transfers are paced by the controller's shift clock, so the serial path has no valid/ready handshake and no back-pressure: every detected rising edge is accepted in the clock cycle in which it is first seen.

Top module: `dbgs_slave`

## Requirements
- R1: A shift-clock rising edge with the qualifier high and execute low moves `dbg_sdi` into the address register MSB-first (`addr <= {addr[6:0], sdi}`). Any other shift edge leaves the address unchanged.
- R2: `board_sel` is high exactly when `addr[7:4] == slot_id` and `dbg_addr_q` is low, so every board is deselected while the qualifier is high.
- R3: A shift edge with the qualifier low, execute low and the board selected shifts the register whose index is `addr[3:0]` MSB-first. Before that edge, `dbg_sdo` shows the register's MSB, so eight edges read out the old byte while loading the new one. Index 0 is the configuration register and index 1 is a scratch register. Any other index reads as 0 and ignores writes.
- R4: A shift edge with execute high transfers nothing into the address or any register. If the board is selected, `exec_strobe` is high for exactly one clock after that edge, and `exec_idx` then holds `addr[3:0]`.
- R5: `dbg_sdo_oe` equals `board_sel`, and `dbg_sdo` is 0 whenever the output is not enabled. Shift edges while not selected change no register.
- R6: When configuration bit 0 is 1, `hyb_sel` is the one-hot decode of configuration bits [5:1] for indices 0..4, and all zero for indices 5..31.
- R7: When configuration bit 0 is 0, `hyb_sel` equals configuration bits [5:1] as a binary number.
- R8: When `dbg_rst_req` and `sync_stop` are both high on 10 consecutive clock edges, `arb_reset` rises after the 10th edge and stays high while both remain high. A break before the 10th edge restarts the count. Each clock edge with `arb_reset` high clears the address and all registers.
- R9: After `rst_n`, the address and all registers are 0, and `arb_reset` and `exec_strobe` are low.
- R10: A shift clock held high for several clocks counts as one rising edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_sck | input | 1 | Debug shift clock (level, sampled on clk) |
| dbg_addr_q | input | 1 | High: shift edges carry address bits |
| dbg_exec | input | 1 | High: next shift edge is an execute cycle |
| dbg_sdi | input | 1 | Serial data/address in |
| slot_id | input | 4 | Board slot number |
| dbg_rst_req | input | 1 | Debug reset request |
| sync_stop | input | 1 | Synchronous stop, qualifies debug reset |
| dbg_sdo | output | 1 | Serial data out |
| dbg_sdo_oe | output | 1 | Output enable for the serial out pad |
| board_sel | output | 1 | Board selected |
| hyb_sel | output | 5 | Component select, one-hot or binary |
| exec_strobe | output | 1 | One-clock execute pulse |
| exec_idx | output | 4 | Register index of the execute cycle |
| arb_reset | output | 1 | Block reset from the debug reset hold |

## Verification
Every shift takes effect on the first clock edge at which `dbg_sck` is seen high. `board_sel`, `dbg_sdo` and `hyb_sel` are combinational from the updated state, so they are valid from the next falling clock edge. `exec_strobe` is registered on the execute edge and must be gone one clock later. `arb_reset` must still be low after the 9th qualifying edge and high after the 10th. The bench changes inputs and samples outputs only on falling edges, one clock after the action edge, and checks both the clock where a result is due and the clock before or after it.

// File: rtl/dbgs_pkg.sv
package dbgs_pkg;
  localparam int CFG_IDX  = 0;
  localparam int SCR_IDX  = 1;
  localparam int MODE_BIT = 0;
  localparam int HIDX_LSB = 1;

  typedef struct packed {
    logic addr_shift;
    logic data_shift;
    logic exec;
  } dbgs_op_t;
endpackage

// File: rtl/dbgs_front.sv
module dbgs_front #(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 sck,
  input  logic                 addr_q,
  input  logic                 exec,
  input  logic                 sdi,
  input  logic [SLOT_W-1:0]    slot_id,
  output logic [ADDR_W-1:0]    addr,
  output logic                 board_sel,
  output dbgs_pkg::dbgs_op_t   op
);
  logic sck_q;
  logic rise;

  assign rise          = sck & ~sck_q;
  assign op.addr_shift = rise & addr_q & ~exec;
  assign op.data_shift = rise & ~addr_q & ~exec;
  assign op.exec       = rise & exec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      addr  <= '0;
    end else begin
      sck_q <= sck;
      if (soft_rst)           addr <= '0;
      else if (op.addr_shift) addr <= {addr[ADDR_W-2:0], sdi};
    end
  end

  assign board_sel = (addr[ADDR_W-1 -: SLOT_W] == slot_id) && !addr_q;

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !addr_q && !soft_rst) |=> $stable(addr));
  assert_exec_noaddr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && exec && !soft_rst) |=> $stable(addr));
  assert_level_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && sck_q && !soft_rst) |=> $stable(addr));
endmodule

// File: rtl/dbgs_regs.sv
module dbgs_regs #(
  parameter int REG_W = 8,
  parameter int NREGS = 2,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             sel,
  input  logic             data_shift,
  input  logic             exec,
  input  logic [IDX_W-1:0] idx,
  input  logic             sdi,
  output logic [REG_W-1:0] cfg,
  output logic             sdo_bit
);
  logic [REG_W-1:0]       regs [NREGS];
  logic [NREGS*REG_W-1:0] flat;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (!rst_n || soft_rst)
        regs[i] <= '0;
      else if (sel && data_shift && idx == IDX_W'(i))
        regs[i] <= {regs[i][REG_W-2:0], sdi};
    end
  end

  always_comb begin
    sdo_bit = 1'b0;
    for (int i = 0; i < NREGS; i++)
      if (idx == IDX_W'(i)) sdo_bit = regs[i][REG_W-1];
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign flat[g*REG_W +: REG_W] = regs[g];
  end

  assign cfg = regs[dbgs_pkg::CFG_IDX];

  assert_unsel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !soft_rst) |=> $stable(flat));
  assert_exec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !soft_rst) |=> $stable(flat));
endmodule

// File: rtl/dbgs_hyb.sv
module dbgs_hyb #(
  parameter int HYB_W = 5
) (
  input  logic             onehot_mode,
  input  logic [HYB_W-1:0] idx,
  output logic [HYB_W-1:0] hyb
);
  logic [HYB_W-1:0] dec;

  for (genvar g = 0; g < HYB_W; g++) begin : g_dec
    assign dec[g] = (idx == HYB_W'(g));
  end

  assign hyb = onehot_mode ? dec : idx;
endmodule

// File: rtl/dbgs_rst_timer.sv
module dbgs_rst_timer #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic stop,
  output logic soft_rst
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic             cond;
  logic [CNT_W-1:0] cnt;

  assign cond = rst_req & stop;

  always_ff @(posedge clk) begin
    if (!rst_n || !cond)           cnt <= '0;
    else if (cnt != CNT_W'(HOLD))  cnt <= cnt + 1'b1;
  end

  assign soft_rst = (cnt == CNT_W'(HOLD));

  assert_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(cond));
  assert_break_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !soft_rst);
endmodule

// File: rtl/dbgs_slave.sv
module dbgs_slave #(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 4,
  parameter int REG_W  = 8,
  parameter int NREGS  = 2,
  parameter int HYB_W  = 5,
  parameter int HOLD   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dbg_sck,
  input  logic                     dbg_addr_q,
  input  logic                     dbg_exec,
  input  logic                     dbg_sdi,
  input  logic [SLOT_W-1:0]        slot_id,
  input  logic                     dbg_rst_req,
  input  logic                     sync_stop,
  output logic                     dbg_sdo,
  output logic                     dbg_sdo_oe,
  output logic                     board_sel,
  output logic [HYB_W-1:0]         hyb_sel,
  output logic                     exec_strobe,
  output logic [ADDR_W-SLOT_W-1:0] exec_idx,
  output logic                     arb_reset
);
  localparam int IDX_W = ADDR_W - SLOT_W;

  logic [ADDR_W-1:0]  addr;
  logic [REG_W-1:0]   cfg;
  logic               sdo_bit;
  logic               soft_rst;
  dbgs_pkg::dbgs_op_t op;

  dbgs_rst_timer #(.HOLD(HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .rst_req(dbg_rst_req), .stop(sync_stop),
    .soft_rst(soft_rst)
  );

  dbgs_front #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sck(dbg_sck),
    .addr_q(dbg_addr_q), .exec(dbg_exec), .sdi(dbg_sdi), .slot_id(slot_id),
    .addr(addr), .board_sel(board_sel), .op(op)
  );

  dbgs_regs #(.REG_W(REG_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(board_sel),
    .data_shift(op.data_shift), .exec(op.exec), .idx(addr[IDX_W-1:0]),
    .sdi(dbg_sdi), .cfg(cfg), .sdo_bit(sdo_bit)
  );

  dbgs_hyb #(.HYB_W(HYB_W)) u_hyb (
    .onehot_mode(cfg[dbgs_pkg::MODE_BIT]),
    .idx(cfg[dbgs_pkg::HIDX_LSB +: HYB_W]),
    .hyb(hyb_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_strobe <= 1'b0;
      exec_idx    <= '0;
    end else begin
      exec_strobe <= op.exec & board_sel & ~soft_rst;
      if (op.exec & board_sel) exec_idx <= addr[IDX_W-1:0];
    end
  end

  assign dbg_sdo_oe = board_sel;
  assign dbg_sdo    = board_sel & sdo_bit;
  assign arb_reset  = soft_rst;
endmodule

// File: tb/dbgs_slave_bench.sv
module dbgs_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 0, aq = 0, ex = 0, sdi = 0, rreq = 0, stp = 0;
  logic [3:0] slot = 4'd5;
  logic sdo, oe, bsel, estb, arst;
  logic [4:0] hyb;
  logic [3:0] eidx;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbgs_slave u_dbgs_slave (
    .clk(clk), .rst_n(rst_n), .dbg_sck(sck), .dbg_addr_q(aq), .dbg_exec(ex),
    .dbg_sdi(sdi), .slot_id(slot), .dbg_rst_req(rreq), .sync_stop(stp),
    .dbg_sdo(sdo), .dbg_sdo_oe(oe), .board_sel(bsel), .hyb_sel(hyb),
    .exec_strobe(estb), .exec_idx(eidx), .arb_reset(arst)
  );

  // {one-hot mode, hybrid index[4:0], expected hyb_sel[4:0]}
  localparam logic [10:0] VEC [9] = '{
    {1'b1, 5'd0,  5'b00001}, {1'b1, 5'd2,  5'b00100}, {1'b1, 5'd4, 5'b10000},
    {1'b1, 5'd5,  5'b00000}, {1'b1, 5'd31, 5'b00000}, {1'b0, 5'd0, 5'b00000},
    {1'b0, 5'd3,  5'b00011}, {1'b0, 5'd31, 5'b11111}, {1'b0, 5'd9, 5'b01001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_edge(input logic q, input logic e, input logic d, output logic so);
    @(negedge clk);
    aq = q; ex = e; sdi = d; sck = 1'b1;
    #1 so = sdo;
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_addr(input logic [7:0] a);
    logic so;
    for (int i = 7; i >= 0; i--) begin
      bit_edge(1'b1, 1'b0, a[i], so);
      if (i == 0) chk("R2 deselect while qualifier high", {31'd0, bsel}, 32'd0);
    end
    aq = 1'b0;
    #1;
  endtask

  task automatic shift_data(input logic [7:0] w, output logic [7:0] r);
    logic so;
    for (int i = 7; i >= 0; i--) begin
      bit_edge(1'b0, 1'b0, w[i], so);
      r[i] = so;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, prev;
    logic so;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 hyb after reset", {27'd0, hyb}, 32'd0);
    chk("R9 arb_reset after reset", {31'd0, arst}, 32'd0);
    chk("R9 exec_strobe after reset", {31'd0, estb}, 32'd0);
    chk("R9 not selected after reset", {31'd0, bsel}, 32'd0);

    shift_addr(8'h50);
    chk("R2 selected on slot match", {31'd0, bsel}, 32'd1);
    chk("R5 oe follows select", {31'd0, oe}, 32'd1);

    // table walk: config write, hyb decode, readback of previous byte
    prev = 8'h00;
    foreach (VEC[k]) begin
      shift_data({2'b00, VEC[k][9:5], VEC[k][10]}, rd);
      @(negedge clk);
      chk(VEC[k][10] ? "R6 one-hot select" : "R7 binary select", {27'd0, hyb}, {27'd0, VEC[k][4:0]});
      chk("R3 readback of previous config", {24'd0, rd}, {24'd0, prev});
      prev = {2'b00, VEC[k][9:5], VEC[k][10]};
    end

    // R5: other board, writes ignored, output quiet
    shift_addr(8'h60);
    chk("R5 oe low when unselected", {31'd0, oe}, 32'd0);
    shift_data(8'hFF, rd);
    chk("R5 sdo low when unselected", {24'd0, rd}, 32'd0);
    chk("R5 hyb unchanged by unselected write", {27'd0, hyb}, 32'b01001);
    shift_addr(8'h50);
    shift_data(8'h12, rd);
    chk("R5 config kept", {24'd0, rd}, 32'h12);

    // R4: execute cycle
    shift_addr(8'h51);
    shift_data(8'hC3, rd);
    chk("R3 scratch reset value", {24'd0, rd}, 32'd0);
    @(negedge clk);
    ex = 1'b1; sdi = 1'b1; sck = 1'b1;
    @(negedge clk);
    chk("R4 strobe after execute edge", {31'd0, estb}, 32'd1);
    chk("R4 execute index", {28'd0, eidx}, 32'd1);
    sck = 1'b0; ex = 1'b0;
    @(negedge clk);
    chk("R4 strobe one clock only", {31'd0, estb}, 32'd0);
    chk("R4 address kept by execute", {31'd0, bsel}, 32'd1);
    shift_data(8'h00, rd);
    chk("R4 scratch not shifted by execute", {24'd0, rd}, 32'hC3);

    // R3: unimplemented index
    shift_addr(8'h53);
    shift_data(8'hAB, rd);
    chk("R3 unimplemented reads zero", {24'd0, rd}, 32'd0);
    shift_data(8'h00, rd);
    chk("R3 unimplemented ignores write", {24'd0, rd}, 32'd0);

    // R10: held shift clock shifts once (0x2B <<1 | 0 = 0x56 selects slot 5)
    shift_addr(8'h2B);
    chk("R10 precondition not selected", {31'd0, bsel}, 32'd0);
    @(negedge clk);
    aq = 1'b1; sdi = 1'b0; sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
    aq = 1'b0;
    #1 chk("R10 single shift on held level", {31'd0, bsel}, 32'd1);

    // R8: debug reset hold
    shift_addr(8'h50);
    @(negedge clk);
    rreq = 1'b1; stp = 1'b1;
    repeat (9) @(negedge clk);
    chk("R8 low after 9 edges", {31'd0, arst}, 32'd0);
    stp = 1'b0;
    @(negedge clk);
    stp = 1'b1;
    repeat (9) @(negedge clk);
    chk("R8 count restarted after break", {31'd0, arst}, 32'd0);
    chk("R8 config intact before reset", {27'd0, hyb}, 32'b01001);
    @(negedge clk);
    chk("R8 high after 10 edges", {31'd0, arst}, 32'd1);
    @(negedge clk);
    chk("R8 stays high while held", {31'd0, arst}, 32'd1);
    rreq = 1'b0; stp = 1'b0;
    @(negedge clk);
    chk("R8 released", {31'd0, arst}, 32'd0);
    chk("R8 config cleared", {27'd0, hyb}, 32'd0);
    chk("R8 address cleared", {31'd0, bsel}, 32'd0);
    bit_edge(1'b0, 1'b0, 1'b0, so);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule